// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block joins two data ports, A and B, through a transceiver that can pass data either way. It holds two independent lanes of eight bits each. Every lane has one holding register per direction: the A-to-B register takes the A-side value and the B-to-A register takes the B-side value. Each register loads on a clock edge when its own capture strobe is high.

The port that is driven in a lane can carry one of two values. It can carry the live value from the opposite port, which passes straight through with no register in the path. It can also carry the value held in that direction's register. A per-lane active-low enable and a direction bit choose which port, if either, is driven. Capture ignores both controls, so a lane can keep recording bus traffic while its outputs are off or turned the other way.

Each port is modelled as three vectors: an input value, an output value and a per-bit output enable. While a port is driven, the value it offers for capture is its own output. When the lanes are set up the same way they act as one 16-bit path.

Top module: `dual_reg_xcvr`

## Requirements
- R1: Synchronous active-high `rst` clears both registers of every lane to zero. After reset, replaying a stored value gives 0x00.
- R2: When a lane's `en_n` is 1, both `a_oe` and `b_oe` are 0 for that lane and both outputs read 0x00.
- R3: When `en_n`=0 and `to_b`=0, that lane's `a_oe` bits are all 1 and its `b_oe` bits are all 0.
- R4: When `en_n`=0 and `to_b`=1, that lane's `b_oe` bits are all 1 and its `a_oe` bits are all 0.
- R5: While A is driven and `sel_reg_b2a`=0, `a_out` equals `b_in` in the same cycle.
- R6: While A is driven and `sel_reg_b2a`=1, `a_out` equals the B-to-A register.
- R7: While B is driven and `sel_reg_a2b`=0, `b_out` equals `a_in` in the same cycle.
- R8: While B is driven and `sel_reg_a2b`=1, `b_out` equals the A-to-B register.
- R9: On a rising `clk` edge with `cap_a2b` (or `cap_b2a`) high, the lane's A-to-B (or B-to-A) register loads the A-side (or B-side) value. This happens whatever `en_n` and `to_b` are set to. With the strobe low, the register keeps its value.
- R10: A register whose source port is being driven loads the driven output value. The external input of that port is ignored.
- R11: Lane 0 uses bits 7:0 and lane 1 uses bits 15:8. The controls of one lane never change the outputs or registers of the other lane.
- R12: In each lane, at no time are `a_oe` and `b_oe` both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding registers |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 2 | Per-lane active-low output enable |
| to_b | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| cap_a2b | input | 2 | Per-lane capture strobe for the A-to-B register |
| cap_b2a | input | 2 | Per-lane capture strobe for the B-to-A register |
| sel_reg_a2b | input | 2 | Per-lane B-side source: 1 stored, 0 live |
| sel_reg_b2a | input | 2 | Per-lane A-side source: 1 stored, 0 live |
| a_in | input | 16 | External value present on port A |
| a_out | output | 16 | Value the block drives onto port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | External value present on port B |
| b_out | output | 16 | Value the block drives onto port B |
| b_oe | output | 16 | Per-bit drive enable for port B |

## Verification
A capture and an output can fall in the same cycle. The hard case is a register that loads from the very port the lane is driving. To provoke it, the bench drives port A live from B while both strobes are high and a conflicting value sits on `a_in`. Both registers must then hold the driven value. The bench confirms this by turning the lane around and replaying the stored data.

A second case has a capture in isolation on one lane happen together with live traffic on the other lane. The bench judges it by reading both lanes' outputs afterwards.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    // Per-lane control bundle
    typedef struct packed {
        logic en_n;      // active-low output enable
        logic to_b;      // 1: drive B, 0: drive A
        logic reg_a2b;   // B-side source select
        logic reg_b2a;   // A-side source select
    } lane_ctl_t;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } lane_drv_t;

    function automatic lane_drv_t decode_drive(lane_ctl_t c);
        lane_drv_t d;
        d.drive_a = ~c.en_n & ~c.to_b;
        d.drive_b = ~c.en_n &  c.to_b;
        return d;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic         cap_a2b,
    input  logic         cap_b2a,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    lane_drv_t    drv;
    logic [W-1:0] q_a2b, q_b2a;
    logic [W-1:0] a_val, b_val;   // value offered onto each port when driven
    logic [W-1:0] a_seen, b_seen; // value present at each port

    assign drv = decode_drive(ctl);

    // Sources are read from raw inputs: only one side is driven at a time,
    // so the opposite side is always an input, and no loop is formed.
    always_comb begin
        a_val  = ctl.reg_b2a ? q_b2a : b_in;
        b_val  = ctl.reg_a2b ? q_a2b : a_in;
        a_seen = drv.drive_a ? a_val : a_in;
        b_seen = drv.drive_b ? b_val : b_in;
    end

    xcvr_store #(.W(W)) u_a2b (
        .clk (clk), .rst (rst), .load (cap_a2b), .d (a_seen), .q (q_a2b)
    );
    xcvr_store #(.W(W)) u_b2a (
        .clk (clk), .rst (rst), .load (cap_b2a), .d (b_seen), .q (q_b2a)
    );

    assign a_out = drv.drive_a ? a_val : '0;
    assign b_out = drv.drive_b ? b_val : '0;
    assign a_oe  = {W{drv.drive_a}};
    assign b_oe  = {W{drv.drive_b}};
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES,
    localparam int TW = LW * NL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] en_n,
    input  logic [NL-1:0] to_b,
    input  logic [NL-1:0] cap_a2b,
    input  logic [NL-1:0] cap_b2a,
    input  logic [NL-1:0] sel_reg_a2b,
    input  logic [NL-1:0] sel_reg_b2a,
    input  logic [TW-1:0] a_in,
    output logic [TW-1:0] a_out,
    output logic [TW-1:0] a_oe,
    input  logic [TW-1:0] b_in,
    output logic [TW-1:0] b_out,
    output logic [TW-1:0] b_oe
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        lane_ctl_t ctl;
        assign ctl = '{en_n: en_n[g], to_b: to_b[g],
                       reg_a2b: sel_reg_a2b[g], reg_b2a: sel_reg_b2a[g]};

        xcvr_lane #(.W(LW)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .cap_a2b (cap_a2b[g]),
            .cap_b2a (cap_b2a[g]),
            .a_in    (a_in [g*LW +: LW]),
            .b_in    (b_in [g*LW +: LW]),
            .a_out   (a_out[g*LW +: LW]),
            .a_oe    (a_oe [g*LW +: LW]),
            .b_out   (b_out[g*LW +: LW]),
            .b_oe    (b_oe [g*LW +: LW])
        );
    end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int LW = 8,
    parameter int NL = 2,
    localparam int TW = LW * NL
) (
    input logic          clk,
    input logic          rst,
    input logic [NL-1:0] en_n,
    input logic [NL-1:0] to_b,
    input logic [NL-1:0] cap_a2b,
    input logic [NL-1:0] cap_b2a,
    input logic [NL-1:0] sel_reg_a2b,
    input logic [NL-1:0] sel_reg_b2a,
    input logic [TW-1:0] a_in,
    input logic [TW-1:0] a_out,
    input logic [TW-1:0] a_oe,
    input logic [TW-1:0] b_in,
    input logic [TW-1:0] b_out,
    input logic [TW-1:0] b_oe
);
    for (genvar g = 0; g < NL; g++) begin : g_chk
        // R12
        a_r12_one_side: assert property (@(posedge clk) disable iff (rst)
            !(a_oe[g*LW] && b_oe[g*LW]));
        // R2
        a_r2_isolated: assert property (@(posedge clk) disable iff (rst)
            en_n[g] |-> (a_oe[g*LW +: LW] == '0 && b_oe[g*LW +: LW] == '0));
        // R5
        a_r5_live_to_a: assert property (@(posedge clk) disable iff (rst)
            (!en_n[g] && !to_b[g] && !sel_reg_b2a[g])
            |-> a_out[g*LW +: LW] == b_in[g*LW +: LW]);
        // R7
        a_r7_live_to_b: assert property (@(posedge clk) disable iff (rst)
            (!en_n[g] && to_b[g] && !sel_reg_a2b[g])
            |-> b_out[g*LW +: LW] == a_in[g*LW +: LW]);
        // R9: an undriven A side captured, then replayed onto B
        a_r9_cap_a2b: assert property (@(posedge clk) disable iff (rst)
            (cap_a2b[g] && !a_oe[g*LW])
            ##1 (!en_n[g] && to_b[g] && sel_reg_a2b[g])
            |-> b_out[g*LW +: LW] == $past(a_in[g*LW +: LW]));
        // R9: an undriven B side captured, then replayed onto A
        a_r9_cap_b2a: assert property (@(posedge clk) disable iff (rst)
            (cap_b2a[g] && !b_oe[g*LW])
            ##1 (!en_n[g] && !to_b[g] && sel_reg_b2a[g])
            |-> a_out[g*LW +: LW] == $past(b_in[g*LW +: LW]));
    end
endmodule

bind dual_reg_xcvr xcvr_checker #(.LW(LW), .NL(NL)) u_chk (
    .clk (clk), .rst (rst), .en_n (en_n), .to_b (to_b),
    .cap_a2b (cap_a2b), .cap_b2a (cap_b2a),
    .sel_reg_a2b (sel_reg_a2b), .sel_reg_b2a (sel_reg_b2a),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
);

// File: tb/dual_reg_xcvr_bench.sv
module dual_reg_xcvr_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  en_n = 2'b11, to_b = 0, cap_a2b = 0, cap_b2a = 0;
    logic [1:0]  sel_reg_a2b = 0, sel_reg_b2a = 0;
    logic [15:0] a_in = 0, b_in = 0;
    logic [15:0] a_out, a_oe, b_out, b_oe;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dual_reg_xcvr u_dual_reg_xcvr (.*);

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // R12 in a lane: enables never both set
    task automatic chk_excl();
        for (int l = 0; l < 2; l++)
            chk("R12", 16'(a_oe[l*8 +: 8] & b_oe[l*8 +: 8]), 16'h0);
    endtask

    task automatic cfg(int l, logic en, logic tb, logic ra, logic rb);
        en_n[l] = en; to_b[l] = tb; sel_reg_a2b[l] = ra; sel_reg_b2a[l] = rb;
    endtask

    task automatic settle();
        @(negedge clk); #2;
    endtask

    task automatic t_reset();
        cfg(0, 0, 1, 1, 0); settle();
        chk("R1 b_out after reset", 16'(b_out[7:0]), 16'h00);
        chk("R4 b_oe", 16'(b_oe[7:0]), 16'hFF);
        chk("R4 a_oe", 16'(a_oe[7:0]), 16'h00);
        cfg(0, 0, 0, 0, 1); settle();
        chk("R1 a_out after reset", 16'(a_out[7:0]), 16'h00);
        chk_excl();
    endtask

    task automatic t_isolation_capture();
        cfg(0, 1, 0, 1, 1);
        a_in[7:0] = 8'h5A; b_in[7:0] = 8'hC3;
        settle();
        chk("R2 oe off", a_oe | b_oe, 16'h0);
        chk("R2 out zero", a_out | b_out, 16'h0);
        cap_a2b[0] = 1; cap_b2a[0] = 1;
        settle();
        cap_a2b[0] = 0; cap_b2a[0] = 0;
        a_in[7:0] = 8'h00; b_in[7:0] = 8'h00;
        cfg(0, 0, 1, 1, 1); settle();
        chk("R9/R8 stored A->B", 16'(b_out[7:0]), 16'h5A);
        cfg(0, 0, 0, 1, 1); settle();
        chk("R9/R6 stored B->A", 16'(a_out[7:0]), 16'hC3);
        chk("R3 a_oe", 16'(a_oe[7:0]), 16'hFF);
        chk("R3 b_oe", 16'(b_oe[7:0]), 16'h00);
        chk_excl();
    endtask

    task automatic t_live();
        cfg(0, 0, 0, 0, 0); b_in[7:0] = 8'h3C; #1;
        chk("R5 live to A", 16'(a_out[7:0]), 16'h3C);
        b_in[7:0] = 8'hE1; #1;
        chk("R5 live follows", 16'(a_out[7:0]), 16'hE1);
        cfg(0, 0, 1, 0, 0); a_in[7:0] = 8'h81; #1;
        chk("R7 live to B", 16'(b_out[7:0]), 16'h81);
        chk_excl();
    endtask

    task automatic t_hold();
        cfg(0, 0, 1, 1, 0); a_in[7:0] = 8'h99;
        settle(); settle();
        chk("R9 hold without strobe", 16'(b_out[7:0]), 16'h5A);
    endtask

    task automatic t_driven_capture();
        // lane 0 drives A live from B; A's external input conflicts
        cfg(0, 0, 0, 0, 0); b_in[7:0] = 8'h77; a_in[7:0] = 8'h11;
        cap_a2b[0] = 1; cap_b2a[0] = 1;
        settle();
        cap_a2b[0] = 0; cap_b2a[0] = 0;
        b_in[7:0] = 8'h00; a_in[7:0] = 8'h00;
        cfg(0, 0, 1, 1, 0); settle();
        chk("R10 driven value captured", 16'(b_out[7:0]), 16'h77);
        cfg(0, 0, 0, 0, 1); settle();
        chk("R9 B->A capture while A driven", 16'(a_out[7:0]), 16'h77);
    endtask

    task automatic t_lanes();
        // lane 0 live to B, lane 1 isolated capturing
        cfg(0, 0, 1, 0, 0); a_in[7:0] = 8'h42;
        cfg(1, 1, 0, 0, 0); a_in[15:8] = 8'hB6; b_in[15:8] = 8'h2D;
        cap_a2b[1] = 1; cap_b2a[1] = 1;
        #1;
        chk("R11 lane0 live with lane1 capturing", 16'(b_out[7:0]), 16'h42);
        chk("R11 lane1 isolated", a_oe[15:8] | b_oe[15:8], 16'h0);
        settle();
        cap_a2b[1] = 0; cap_b2a[1] = 0;
        cfg(0, 0, 1, 1, 0); cfg(1, 0, 1, 1, 0); settle();
        chk("R11 lane0 reg untouched", 16'(b_out[7:0]), 16'h77);
        chk("R11 lane1 stored A->B", 16'(b_out[15:8]), 16'hB6);
        cfg(1, 0, 0, 0, 1); settle();
        chk("R11 lane1 stored B->A", 16'(a_out[15:8]), 16'h2D);
        chk("R11 lane0 unaffected by lane1", 16'(b_out[7:0]), 16'h77);
        chk_excl();
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 during reset", a_oe | b_oe, 16'h0);
        rst = 0;
        t_reset();
        t_isolation_capture();
        t_live();
        t_hold();
        t_driven_capture();
        t_lanes();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule